// File: doc/BRIEF.md
# Two-Wire Escape and Activation Sequencer

This block lets a debug host wake a two-wire scan target. Any reset of the target's test controller puts the target offline and inactive, so the host must run this sequence after every such reset. The block owns the clock pin and the bidirectional data pin (its value and its output enable). It generates every pin level from a system clock. Each pin level lasts one programmed half-period of `HALF_CYC` system clocks.

A `start` pulse runs three steps in a fixed order:

1. **Reset escape.** The data line toggles while the scan clock stays high.
2. **Select escape.** The same pattern with fewer toggles.
3. **Activation packet.** Twelve bits clocked on scan-clock rising edges.

When the sequence ends, the block parks the scan clock low, releases the data line and raises `done`. Scan traffic after that point is outside this block. An external multiplexer returns the pins to the serializer.

Time is divided into slots of `HALF_CYC` clocks each. With the default parameters the sequence has 43 slots:

| Step | Slots |
|---|---|
| Baseline | 1 |
| Reset escape | 10 |
| Select escape | 8 |
| Packet | 24 |

The pin outputs are registered, so they lag the internal phase by one clock.

Top module: `tw_activate_seq`

## Requirements
- R1: After reset is applied, and while no sequence has been started, `tck`, `dat_o`, `dat_oe` and `done` are all 0.
- R2: Suppose `start` is sampled high on clock edge S while the block is idle. From edge S+1 onward, for `HALF_CYC` clocks, the outputs hold the baseline: `tck`=0, `dat_o`=0, `dat_oe`=1 and `done`=0.
- R3: The reset escape is one slot of `tck`=1 with `dat_o`=0, then `RST_EDGES` (8) slots with `tck` held at 1 and `dat_o` alternating 1,0,1,0,... ending at 0, then one slot of `tck`=0 with `dat_o`=0.
- R4: The select escape has the same form as R3, with `SEL_EDGES` (6) toggle slots.
- R5: The packet is `PKT_BITS` (12) bits, sent bit 0 first from `PKT_CODE` = 12'h08C. In time order the bits are 0,0,1,1 (activation code), then 0,0,0,1 (extension code), then 0,0,0,0 (check field). Each bit takes one slot with `tck`=0 and `dat_o`=bit, followed by one slot with `tck`=1 and the same bit.
- R6: Every slot lasts exactly `HALF_CYC` clocks. While the line is driven, neither `tck` nor `dat_o` changes sooner than `HALF_CYC` clocks after its previous change.
- R7: `done` rises at edge S+43·`HALF_CYC`+1, with `tck`=0, `dat_o`=0 and `dat_oe`=0. All four outputs then hold until the next accepted `start`.
- R8: A `start` sampled while a sequence is running has no effect on the outputs. This includes a `start` on the last clock of the final slot.
- R9: A `start` sampled while `done` is high restarts the full sequence from the baseline. If `start` is held high, the sequences run back to back, with one `done` clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence when the block is idle or done |
| tck | output | 1 | Scan clock pin level |
| dat_o | output | 1 | Data pin output level |
| dat_oe | output | 1 | Data pin output enable |
| done | output | 1 | Sequence complete, held until the next start |

## Verification
A wrong phase or counter value in this block is visible at the pins within one slot. The symptoms are:

- an early or late scan-clock edge;
- a missing or extra toggle in an escape;
- a flipped packet bit;
- a `done` that arrives at the wrong clock.

Any of these shows up at most `HALF_CYC`+1 clocks after the fault. The bench therefore compares all four outputs against a slot-by-slot queue model on every clock. It also exercises `start` at the exact boundaries where it must be ignored or accepted.

// File: rtl/tw_act_pkg.sv
package tw_act_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_BASE,
      PH_RHI,
      PH_RTOG,
      PH_RLO,
      PH_SHI,
      PH_STOG,
      PH_SLO,
      PH_PLO,
      PH_PHI,
      PH_FIN
   } tw_phase_e;

   typedef struct packed {
      logic tck;
      logic dat;
      logic oe;
      logic done;
   } tw_pins_t;

   function automatic int unsigned tw_max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/tw_halfper_timer.sv
module tw_halfper_timer #(
   parameter int unsigned HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_CYC == 1) begin : g_direct
         // One clock per slot: every clock ends a slot.
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned TW = $clog2(HALF_CYC);
         logic [TW-1:0] cnt_q;

         assign tick = (cnt_q == TW'(HALF_CYC - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || tick)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            {1'b0, cnt_q} < (TW + 1)'(HALF_CYC));
      end
   endgenerate

endmodule

// File: rtl/tw_esc_fsm.sv
module tw_esc_fsm
   import tw_act_pkg::*;
#(
   parameter int unsigned RST_EDGES = 8,
   parameter int unsigned SEL_EDGES = 6,
   parameter int unsigned PKT_BITS  = 12,
   parameter int unsigned CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   output tw_phase_e        phase,
   output logic [CNT_W-1:0] cnt,
   output logic             run
);

   tw_phase_e        ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic             can_start;

   assign can_start = (ph_q == PH_IDLE) || (ph_q == PH_FIN);
   assign run       = !can_start;
   assign phase     = ph_q;
   assign cnt       = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (can_start) begin
         if (start) begin
            ph_q  <= PH_BASE;
            cnt_q <= '0;
         end
      end else if (tick) begin
         unique case (ph_q)
            PH_BASE: ph_q <= PH_RHI;
            PH_RHI: begin
               ph_q  <= PH_RTOG;
               cnt_q <= '0;
            end
            PH_RTOG: begin
               if (cnt_q == CNT_W'(RST_EDGES - 1))
                  ph_q <= PH_RLO;
               else
                  cnt_q <= cnt_q + 1'b1;
            end
            PH_RLO: ph_q <= PH_SHI;
            PH_SHI: begin
               ph_q  <= PH_STOG;
               cnt_q <= '0;
            end
            PH_STOG: begin
               if (cnt_q == CNT_W'(SEL_EDGES - 1))
                  ph_q <= PH_SLO;
               else
                  cnt_q <= cnt_q + 1'b1;
            end
            PH_SLO: begin
               ph_q  <= PH_PLO;
               cnt_q <= '0;
            end
            PH_PLO: ph_q <= PH_PHI;
            PH_PHI: begin
               if (cnt_q == CNT_W'(PKT_BITS - 1))
                  ph_q <= PH_FIN;
               else begin
                  ph_q  <= PH_PLO;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && start) |=> ph_q == PH_BASE);

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_FIN && start) |=> ph_q == PH_BASE);

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && run && ph_q != PH_BASE) |=> ph_q != PH_BASE);

   p_rst_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_RTOG) |-> {1'b0, cnt_q} < (CNT_W + 1)'(RST_EDGES));

   p_sel_toggles_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_STOG) |-> {1'b0, cnt_q} < (CNT_W + 1)'(SEL_EDGES));

   p_pkt_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PLO || ph_q == PH_PHI) |-> {1'b0, cnt_q} < (CNT_W + 1)'(PKT_BITS));

   p_pkt_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PHI && tick) |=> (ph_q == PH_PLO || ph_q == PH_FIN));

endmodule

// File: rtl/tw_pin_drive.sv
module tw_pin_drive
   import tw_act_pkg::*;
#(
   parameter int unsigned          HALF_CYC = 4,
   parameter int unsigned          PKT_BITS = 12,
   parameter logic [PKT_BITS-1:0]  PKT_CODE = 12'h08C,
   parameter int unsigned          CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tw_phase_e        phase,
   input  logic [CNT_W-1:0] cnt,
   output tw_pins_t         pins
);

   tw_pins_t nxt;
   tw_pins_t pins_q;

   always_comb begin
      nxt = '0;
      unique case (phase)
         PH_IDLE: nxt = '0;
         PH_BASE, PH_RLO, PH_SLO: nxt.oe = 1'b1;
         PH_RHI, PH_SHI: begin
            nxt.tck = 1'b1;
            nxt.oe  = 1'b1;
         end
         PH_RTOG, PH_STOG: begin
            nxt.tck = 1'b1;
            nxt.oe  = 1'b1;
            nxt.dat = ~cnt[0];
         end
         PH_PLO: begin
            nxt.oe  = 1'b1;
            nxt.dat = PKT_CODE[cnt];
         end
         PH_PHI: begin
            nxt.tck = 1'b1;
            nxt.oe  = 1'b1;
            nxt.dat = PKT_CODE[cnt];
         end
         PH_FIN:  nxt.done = 1'b1;
         default: nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pins_q <= '0;
      else
         pins_q <= nxt;
   end

   assign pins = pins_q;

   // Dwell checker: clocks since the driven clock or data level last changed.
   localparam int unsigned HW = $clog2(HALF_CYC + 1);
   logic [HW-1:0] hold_q;
   logic          pin_move;

   assign pin_move = (nxt.tck != pins_q.tck) || (nxt.dat != pins_q.dat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (pin_move)
         hold_q <= '0;
      else if (hold_q != HW'(HALF_CYC))
         hold_q <= hold_q + 1'b1;
   end

   p_min_dwell_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_move && pins_q.oe && nxt.oe) |-> {1'b0, hold_q} >= (HW + 1)'(HALF_CYC - 1));

endmodule

// File: rtl/tw_activate_seq.sv
module tw_activate_seq
   import tw_act_pkg::*;
#(
   parameter int unsigned          HALF_CYC  = 4,
   parameter int unsigned          RST_EDGES = 8,
   parameter int unsigned          SEL_EDGES = 6,
   parameter int unsigned          PKT_BITS  = 12,
   parameter logic [PKT_BITS-1:0]  PKT_CODE  = 12'h08C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic tck,
   output logic dat_o,
   output logic dat_oe,
   output logic done
);

   localparam int unsigned CNT_MAX = tw_max3(RST_EDGES, SEL_EDGES, PKT_BITS);
   localparam int unsigned CNT_W   = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (RST_EDGES < 2 || (RST_EDGES % 2) != 0) begin : g_bad_rst
         $error("RST_EDGES must be even and at least 2");
      end
      if (SEL_EDGES < 2 || (SEL_EDGES % 2) != 0) begin : g_bad_sel
         $error("SEL_EDGES must be even and at least 2");
      end
      if (PKT_BITS < 1) begin : g_bad_pkt
         $error("PKT_BITS must be at least 1");
      end
   endgenerate

   tw_phase_e        phase;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             tick;
   tw_pins_t         pins;

   tw_halfper_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   tw_esc_fsm #(
      .RST_EDGES (RST_EDGES),
      .SEL_EDGES (SEL_EDGES),
      .PKT_BITS  (PKT_BITS),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .tick  (tick),
      .phase (phase),
      .cnt   (cnt),
      .run   (run)
   );

   tw_pin_drive #(
      .HALF_CYC (HALF_CYC),
      .PKT_BITS (PKT_BITS),
      .PKT_CODE (PKT_CODE),
      .CNT_W    (CNT_W)
   ) u_pins (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase),
      .cnt   (cnt),
      .pins  (pins)
   );

   assign tck    = pins.tck;
   assign dat_o  = pins.dat;
   assign dat_oe = pins.oe;
   assign done   = pins.done;

   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(start)) |=> done);

   p_release_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_oe) |-> (done && !tck));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dat_oe && !done) |-> (!tck && !dat_o));

endmodule

// File: tb/tw_activate_seq_tb.sv
module tw_activate_seq_tb;

   localparam int H     = 3;
   localparam int NSLOT = 43;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic tck, dat_o, dat_oe, done;

   always #4 clk = ~clk;

   tw_activate_seq #(.HALF_CYC(H)) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .tck    (tck),
      .dat_o  (dat_o),
      .dat_oe (dat_oe),
      .done   (done)
   );

   typedef struct {
      logic [3:0] v;
      string      req;
   } exp_t;

   exp_t       q[$];
   logic [3:0] exp_v   = 4'b0000;
   string      exp_req = "R1";
   string      scen    = "reset";
   bit         ran     = 1'b0;
   bit         chk_en  = 1'b0;
   int         n_chk   = 0;
   int         n_fail  = 0;

   // Packet in time order: activation code, extension code, check field.
   int pkt_bits[12] = '{0, 0, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0};

   function automatic void add_slot(logic t, logic d, string r);
      for (int i = 0; i < H; i++) q.push_back('{v: {t, d, 1'b1, 1'b0}, req: r});
   endfunction

   function automatic void build_seq(bit restart);
      add_slot(1'b0, 1'b0, restart ? "R9" : "R2");
      add_slot(1'b1, 1'b0, "R3");
      for (int k = 0; k < 8; k++) add_slot(1'b1, (k % 2) == 0, "R3");
      add_slot(1'b0, 1'b0, "R3");
      add_slot(1'b1, 1'b0, "R4");
      for (int k = 0; k < 6; k++) add_slot(1'b1, (k % 2) == 0, "R4");
      add_slot(1'b0, 1'b0, "R4");
      for (int b = 0; b < 12; b++) begin
         add_slot(1'b0, pkt_bits[b] != 0, "R5");
         add_slot(1'b1, pkt_bits[b] != 0, "R5");
      end
   endfunction

   // Reference model: one queue entry per clock.
   always @(posedge clk) begin
      bit   acc;
      exp_t e;
      if (!rst_n) begin
         q.delete();
         exp_v   = 4'b0000;
         exp_req = "R1";
         ran     = 1'b0;
      end else begin
         acc = (q.size() == 0) && start;
         if (q.size() > 0) begin
            e       = q.pop_front();
            exp_v   = e.v;
            exp_req = e.req;
         end else if (ran) begin
            exp_v   = 4'b0001;
            exp_req = "R7";
         end
         if (acc) begin
            build_seq(ran);
            ran = 1'b1;
         end
      end
   end

   // Per-clock comparison against the model.
   always @(negedge clk) begin
      if (chk_en) begin
         n_chk++;
         if ({tck, dat_o, dat_oe, done} !== exp_v) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t: got tck/dat/oe/done=%b expected %b",
                     exp_req, scen, $time, {tck, dat_o, dat_oe, done}, exp_v);
         end
      end
   end

   // R6: minimum dwell between driven pin changes.
   logic [1:0] prev_td = 2'b00;
   logic       prev_oe = 1'b0;
   int         gap     = 1;
   always @(negedge clk) begin
      if (chk_en && dat_oe && prev_oe) begin
         if ({tck, dat_o} != prev_td) begin
            n_chk++;
            if (gap < H) begin
               n_fail++;
               $display("FAIL R6 [%s]: pin level held %0d clocks, expected at least %0d", scen, gap, H);
            end
            gap = 1;
         end else begin
            gap++;
         end
      end else begin
         gap = 1;
      end
      prev_td = {tck, dat_o};
      prev_oe = dat_oe;
   end

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: got sequence still running, expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (2) @(posedge clk);
      chk_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // R2..R7: single sequence, measure done latency.
      scen = "R2 single run";
      pulse_start();
      n = 0;
      while (!done && n < 10000) begin
         @(negedge clk);
         n++;
      end
      n_chk++;
      if (n != NSLOT * H + 1) begin
         n_fail++;
         $display("FAIL R7: done after %0d clocks, expected %0d", n, NSLOT * H + 1);
      end
      scen = "R7 done hold";
      repeat (40) @(negedge clk);

      // R8: start pulses during a run, including on the final slot clock.
      scen = "R8 busy start";
      pulse_start();
      for (int i = 0; i < NSLOT * H + 12; i++) begin
         start = (i == 4) || (i == 40) || (i == NSLOT * H - 1);
         @(negedge clk);
      end
      start = 1'b0;
      repeat (10) @(negedge clk);

      // R9: start held high runs sequences back to back.
      scen = "R9 level start";
      start = 1'b1;
      repeat (2 * NSLOT * H + 20) @(negedge clk);
      start = 1'b0;
      repeat (NSLOT * H + 20) @(negedge clk);

      // R1: reset in the middle of a run returns to idle.
      scen = "R1 reset mid-run";
      pulse_start();
      repeat (30) @(negedge clk);
      chk_en = 1'b0;
      rst_n  = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk_en = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      scen = "R2 after reset";
      pulse_start();
      repeat (NSLOT * H + 10) @(negedge clk);

      finish_run();
   end

endmodule